// File: doc/BRIEF.md
# Paged and Banked Register Address Translator

This block sits between an 8-bit core's operand decoder and its register-file storage. Each cycle the core presents a logical register address and an access class. The block returns a flat physical index into one linear storage array. It also returns a flag when the location lies in the system-register space, and a flag when no storage exists behind the address. The access class is one of: direct register, pointer-based (indirect or indexed), working-register, or reserved.

Two pieces of state shape the result, and both are held here. The first is a 2-bit page pointer, which picks the page for the low 192 logical addresses. The second is a bank bit, which picks one of two 32-byte banks behind the top of the direct window. Both load on a clock edge after their strobe and both clear on reset. The top 64 logical addresses (C0h–FFh) do not depend on the page in direct mode. In pointer-based mode the same addresses reach a different, second storage area.

There is no data stream in this block. The address path is purely combinational and the state loads are single-cycle strobes, so every pin is a plain control or status signal. No back-pressure applies.

Top module: `regmap_xlate`

## Requirements
- R1: In direct or pointer-based class with page 0 or 1, an address in 00h–BFh maps to index page*192 + address, with both flags low.
- R2: With page 2, addresses 00h–3Fh map to 384 + address, and 40h–BFh are unmapped. With page 3 the whole range 00h–BFh is unmapped.
- R3: Direct class E0h–FFh maps to 480 + bank*32 + (address − E0h). A bank command loads the bank bit on the next rising edge, and the bank holds when no command is given.
- R4: Reset clears the bank bit to 0 and the page pointer to 0.
- R5: Direct class D0h–DFh maps to 464 + (address − D0h) with the system flag set. The system flag is low for every other access.
- R6: Working-register class (code 2) maps to 448 + address[3:0] for any page, and the upper nibble is ignored. Direct class C0h–CFh is unmapped.
- R7: Pointer-based class (code 1) C0h–FFh maps to 544 + (address − C0h) on page 0, and C0h–FBh maps to 608 + (address − C0h) on page 1. FCh–FFh on page 1 and all of C0h–FFh on pages 2 and 3 are unmapped. The bank bit has no effect here.
- R8: An unmapped access, including every access with class code 3, drives index 0 with the system flag low.
- R9: A page write strobe loads the page pointer on the next rising edge, and the pointer holds when no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lg_addr | input | 8 | Logical register address |
| acc_cls | input | 2 | Access class: 0 direct, 1 pointer-based, 2 working, 3 reserved |
| bank_cmd | input | 1 | Bank select command strobe |
| bank_pick | input | 1 | Bank to select with the command |
| page_we | input | 1 | Page pointer write strobe |
| page_din | input | 2 | Page pointer value to load |
| phys_idx | output | 10 | Flat physical storage index |
| sys_hit | output | 1 | Access lands in system-register space |
| unmapped | output | 1 | No storage behind this access |
| cur_bank | output | 1 | Current bank bit |
| cur_page | output | 2 | Current page pointer |

## Verification
The bench builds the block with its default parameters: 192-byte full pages, a 64-byte partial third page, two 32-byte banks and a 60-byte second pointer window on page 1. With these values a 2-bit page pointer reaches the unused page 3, and the 2-bit class input reaches the reserved code. An exhaustive sweep therefore covers all 256 addresses under all four classes, four pages and both banks, including the FBh/FCh edge on page 1. Directed tasks cover the one-edge latency of the bank and page loads and a reset taken mid-run.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  typedef enum logic [1:0] {
    AC_DIRECT   = 2'd0,
    AC_POINTER  = 2'd1,
    AC_WORKING  = 2'd2,
    AC_RESERVED = 2'd3
  } acc_cls_e;
endpackage

// File: rtl/regmap_state.sv
module regmap_state #(
  parameter int PAGE_W = 2,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_cmd,
  input  logic [BANK_W-1:0] bank_pick,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_din,
  output logic [BANK_W-1:0] bank_q,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      page_q <= '0;
    end else begin
      if (bank_cmd) bank_q <= bank_pick;
      if (page_we)  page_q <= page_din;
    end
  end
endmodule

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
#(
  parameter int PAGE_SPAN   = 192,
  parameter int FULL_PAGES  = 2,
  parameter int PART_SPAN   = 64,
  parameter int COMMON_SPAN = 16,
  parameter int SYS_SPAN    = 16,
  parameter int BANK_SPAN   = 32,
  parameter int NUM_BANKS   = 2,
  parameter int P1_SPAN     = 60,
  parameter int PAGE_W      = 2,
  parameter int BANK_W      = 1,
  parameter int IDX_W       = 10
) (
  input  logic [7:0]        lg_addr,
  input  acc_cls_e          cls,
  input  logic [BANK_W-1:0] bank,
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx,
  output logic              sys_hit,
  output logic              unmapped
);
  localparam int WIN_SPAN    = 256 - PAGE_SPAN;
  localparam int PART_BASE   = FULL_PAGES * PAGE_SPAN;
  localparam int COMMON_BASE = PART_BASE + PART_SPAN;
  localparam int SYS_BASE    = COMMON_BASE + COMMON_SPAN;
  localparam int BANK_BASE   = SYS_BASE + SYS_SPAN;
  localparam int PTR_BASE    = BANK_BASE + NUM_BANKS * BANK_SPAN;
  localparam int PTR1_BASE   = PTR_BASE + WIN_SPAN;

  localparam logic [7:0] WIN_LO  = 8'(PAGE_SPAN);
  localparam logic [7:0] SYS_LO  = 8'(PAGE_SPAN + COMMON_SPAN);
  localparam logic [7:0] BANK_LO = 8'(256 - BANK_SPAN);
  localparam logic [7:0] P1_END  = 8'(PAGE_SPAN + P1_SPAN);

  logic [IDX_W-1:0] a_x, win_off, page_base;
  assign a_x       = IDX_W'(lg_addr);
  assign win_off   = IDX_W'(lg_addr - WIN_LO);
  assign page_base = IDX_W'(page) * IDX_W'(PAGE_SPAN);

  always_comb begin
    idx      = '0;
    sys_hit  = 1'b0;
    unmapped = 1'b1;
    unique case (cls)
      AC_WORKING: begin
        idx      = IDX_W'(COMMON_BASE) + IDX_W'(lg_addr[3:0]);
        unmapped = 1'b0;
      end
      AC_DIRECT, AC_POINTER: begin
        if (lg_addr < WIN_LO) begin
          if (int'(page) < FULL_PAGES) begin
            idx      = page_base + a_x;
            unmapped = 1'b0;
          end else if (int'(page) == FULL_PAGES && int'(lg_addr) < PART_SPAN) begin
            idx      = IDX_W'(PART_BASE) + a_x;
            unmapped = 1'b0;
          end
        end else if (cls == AC_DIRECT) begin
          if (lg_addr >= BANK_LO) begin
            idx      = IDX_W'(BANK_BASE) + IDX_W'(bank) * IDX_W'(BANK_SPAN)
                       + IDX_W'(lg_addr - BANK_LO);
            unmapped = 1'b0;
          end else if (lg_addr >= SYS_LO) begin
            idx      = IDX_W'(SYS_BASE) + IDX_W'(lg_addr - SYS_LO);
            sys_hit  = 1'b1;
            unmapped = 1'b0;
          end
        end else begin
          if (page == '0) begin
            idx      = IDX_W'(PTR_BASE) + win_off;
            unmapped = 1'b0;
          end else if (int'(page) == 1 && lg_addr < P1_END) begin
            idx      = IDX_W'(PTR1_BASE) + win_off;
            unmapped = 1'b0;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regmap_xlate.sv
module regmap_xlate
  import regmap_pkg::*;
#(
  parameter int PAGE_SPAN   = 192,
  parameter int FULL_PAGES  = 2,
  parameter int PART_SPAN   = 64,
  parameter int COMMON_SPAN = 16,
  parameter int SYS_SPAN    = 16,
  parameter int BANK_SPAN   = 32,
  parameter int NUM_BANKS   = 2,
  parameter int P1_SPAN     = 60,
  parameter int PAGE_W      = 2,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int TOTAL      = FULL_PAGES * PAGE_SPAN + PART_SPAN + COMMON_SPAN
                              + SYS_SPAN + NUM_BANKS * BANK_SPAN
                              + (256 - PAGE_SPAN) + P1_SPAN,
  localparam int IDX_W      = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        lg_addr,
  input  logic [1:0]        acc_cls,
  input  logic              bank_cmd,
  input  logic [BANK_W-1:0] bank_pick,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_din,
  output logic [IDX_W-1:0]  phys_idx,
  output logic              sys_hit,
  output logic              unmapped,
  output logic [BANK_W-1:0] cur_bank,
  output logic [PAGE_W-1:0] cur_page
);
  acc_cls_e cls;
  assign cls = acc_cls_e'(acc_cls);

  regmap_state #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) i_state (
    .clk(clk), .rst_n(rst_n),
    .bank_cmd(bank_cmd), .bank_pick(bank_pick),
    .page_we(page_we), .page_din(page_din),
    .bank_q(cur_bank), .page_q(cur_page)
  );

  regmap_decode #(
    .PAGE_SPAN(PAGE_SPAN), .FULL_PAGES(FULL_PAGES), .PART_SPAN(PART_SPAN),
    .COMMON_SPAN(COMMON_SPAN), .SYS_SPAN(SYS_SPAN), .BANK_SPAN(BANK_SPAN),
    .NUM_BANKS(NUM_BANKS), .P1_SPAN(P1_SPAN), .PAGE_W(PAGE_W),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) i_decode (
    .lg_addr(lg_addr), .cls(cls), .bank(cur_bank), .page(cur_page),
    .idx(phys_idx), .sys_hit(sys_hit), .unmapped(unmapped)
  );
endmodule

// File: rtl/regmap_xlate_chk.sv
module regmap_xlate_chk #(
  parameter int PAGE_W = 2,
  parameter int BANK_W = 1,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        lg_addr,
  input logic [1:0]        acc_cls,
  input logic              bank_cmd,
  input logic [BANK_W-1:0] bank_pick,
  input logic              page_we,
  input logic [PAGE_W-1:0] page_din,
  input logic [IDX_W-1:0]  phys_idx,
  input logic              sys_hit,
  input logic              unmapped,
  input logic [BANK_W-1:0] cur_bank,
  input logic [PAGE_W-1:0] cur_page
);
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd |=> cur_bank == $past(bank_pick)); // R3
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_cmd |=> $stable(cur_bank)); // R3
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> cur_page == $past(page_din)); // R9
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> $stable(cur_page)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cur_bank == '0 && cur_page == '0)); // R4
  AST_UNMAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (phys_idx == '0 && !sys_hit)); // R8
  AST_SYS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit |-> (acc_cls == 2'd0 && lg_addr[7:4] == 4'hD)); // R5
  AST_RSVD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cls == 2'd3 |-> unmapped); // R8
endmodule

bind regmap_xlate regmap_xlate_chk #(
  .PAGE_W(PAGE_W), .BANK_W(BANK_W), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .lg_addr(lg_addr), .acc_cls(acc_cls),
  .bank_cmd(bank_cmd), .bank_pick(bank_pick), .page_we(page_we),
  .page_din(page_din), .phys_idx(phys_idx), .sys_hit(sys_hit),
  .unmapped(unmapped), .cur_bank(cur_bank), .cur_page(cur_page)
);

// File: tb/test_regmap_xlate.sv
`timescale 1ns/1ps
module test_regmap_xlate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lg_addr = 8'h00;
  logic [1:0] acc_cls = 2'd0;
  logic       bank_cmd = 1'b0;
  logic [0:0] bank_pick = 1'b0;
  logic       page_we = 1'b0;
  logic [1:0] page_din = 2'd0;
  logic [9:0] phys_idx;
  logic       sys_hit, unmapped;
  logic [0:0] cur_bank;
  logic [1:0] cur_page;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  regmap_xlate i_regmap_xlate (
    .clk(clk), .rst_n(rst_n), .lg_addr(lg_addr), .acc_cls(acc_cls),
    .bank_cmd(bank_cmd), .bank_pick(bank_pick), .page_we(page_we),
    .page_din(page_din), .phys_idx(phys_idx), .sys_hit(sys_hit),
    .unmapped(unmapped), .cur_bank(cur_bank), .cur_page(cur_page)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: {unmapped, sys, idx[9:0]} from the requirements
  function automatic logic [11:0] ref_map(int a, int c, int p, int b);
    if (c == 2) return {2'b00, 10'(448 + (a % 16))};
    if (c == 3) return 12'h800;
    if (a < 192) begin
      if (p < 2) return {2'b00, 10'(p * 192 + a)};
      if (p == 2 && a < 64) return {2'b00, 10'(384 + a)};
      return 12'h800;
    end
    if (c == 0) begin
      if (a >= 224) return {2'b00, 10'(480 + b * 32 + a - 224)};
      if (a >= 208) return {2'b01, 10'(464 + a - 208)};
      return 12'h800;
    end
    if (p == 0) return {2'b00, 10'(544 + a - 192)};
    if (p == 1 && a < 252) return {2'b00, 10'(608 + a - 192)};
    return 12'h800;
  endfunction

  function automatic string req_of(int a, int c, int p);
    if (c == 2) return "R6";
    if (c == 3) return "R8";
    if (a < 192) return (p < 2) ? "R1" : "R2";
    if (c == 0) return (a >= 224) ? "R3" : (a >= 208) ? "R5" : "R6";
    return "R7";
  endfunction

  task automatic set_page(input int p);
    @(negedge clk); page_we = 1'b1; page_din = 2'(p);
    @(negedge clk); page_we = 1'b0;
  endtask

  task automatic set_bank(input int b);
    @(negedge clk); bank_cmd = 1'b1; bank_pick = 1'(b);
    @(negedge clk); bank_cmd = 1'b0;
  endtask

  task automatic probe(input int a, input int c, input string req);
    logic [11:0] e;
    lg_addr = 8'(a); acc_cls = 2'(c);
    #1;
    e = ref_map(a, c, int'(cur_page), int'(cur_bank));
    chk(req, "idx", int'(phys_idx), int'(e[9:0]));
    chk(req, "sys", int'(sys_hit), int'(e[10]));
    chk(req, "unmapped", int'(unmapped), int'(e[11]));
  endtask

  task automatic t_reset;
    #1;
    chk("R4", "bank in reset", int'(cur_bank), 0);
    chk("R4", "page in reset", int'(cur_page), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    probe(8'hE0, 0, "R4");
    set_bank(1); set_page(1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R4", "bank after mid reset", int'(cur_bank), 0);
    chk("R4", "page after mid reset", int'(cur_page), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_bank_timing;
    @(negedge clk); bank_cmd = 1'b1; bank_pick = 1'b1; #1;
    chk("R3", "bank before edge", int'(cur_bank), 0);
    @(negedge clk); bank_cmd = 1'b0;
    chk("R3", "bank after edge", int'(cur_bank), 1);
    bank_pick = 1'b0;
    @(negedge clk);
    chk("R3", "bank held without cmd", int'(cur_bank), 1);
    probe(8'hFF, 0, "R3");
    set_bank(0);
    chk("R3", "bank back to 0", int'(cur_bank), 0);
  endtask

  task automatic t_page_timing;
    @(negedge clk); page_we = 1'b1; page_din = 2'd2; #1;
    chk("R9", "page before edge", int'(cur_page), 0);
    @(negedge clk); page_we = 1'b0;
    chk("R9", "page after edge", int'(cur_page), 2);
    page_din = 2'd1;
    @(negedge clk);
    chk("R9", "page held without strobe", int'(cur_page), 2);
    probe(8'h3F, 1, "R2");
    probe(8'h40, 1, "R2");
    set_page(0);
  endtask

  task automatic t_working_nibble;
    set_page(3);
    probe(8'h05, 2, "R6");
    probe(8'hF5, 2, "R6");
    chk("R6", "upper nibble ignored", int'(phys_idx), 448 + 5);
    probe(8'hC7, 0, "R6");
    set_page(0);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 2; b++) begin
        set_page(p); set_bank(b);
        chk("R9", "page loaded", int'(cur_page), p);
        chk("R3", "bank loaded", int'(cur_bank), b);
        for (int c = 0; c < 4; c++)
          for (int a = 0; a < 256; a++)
            probe(a, c, req_of(a, c, p));
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bank_timing();
    t_page_timing();
    t_working_nibble();
    t_sweep();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule